// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel. It produces one bus access per start pulse. All of its timing comes from a single packed 32-bit timing word. Each access is one of two kinds, selected when the access starts:

- a data access (PIO or multiword DMA);
- a command access (task-file register).

Each kind has its own group of fields in the word. An access runs in three phases:

1. a setup phase, with both strobes high;
2. an active phase, with the selected strobe low;
3. a recovery phase, with both strobes high again.

Each phase is counted in bus clock cycles. When the recovery phase ends, a one-cycle done pulse is raised.

A channel controller loads the timing word for the attached device's transfer mode. It then raises start for one cycle, with the direction and access kind set. It may issue the next access in the cycle in which done is seen. The timing word, direction and kind are captured when start is accepted. After that, these inputs may change freely.

Top module: `ata_strobe_timer`

## Requirements
- R1: For a data access (`is_cmd`=0), the setup phase is taken from word bits 24:22. It lasts that value plus one cycles. It starts in the cycle after start is accepted, and both strobes stay high during it.
- R2: For a data access, the active phase is taken from bits 8:4. It lasts that value plus one cycles, and the selected strobe is low for exactly that many cycles.
- R3: For a data access, the recovery phase is taken from bits 3:0. It lasts that value plus one cycles, with both strobes high and busy high.
- R4: For a command access (`is_cmd`=1), the three phases use different fields. Setup comes from bits 27:25, active from bits 17:13 and recovery from bits 12:9. Each phase lasts its field value plus one cycles.
- R5: Bits 31:28 and bits 21:18 have no effect on the strobe waveform.
- R6: The timing word, `is_write` and `is_cmd` are captured in the cycle start is accepted. Changing them later does not alter the access in progress.
- R7: A start pulse that arrives while busy is high is ignored. It neither restarts the access nor queues a further one.
- R8: With `is_write`=1 only `wr_n` goes low, and with `is_write`=0 only `rd_n` goes low. The other strobe stays high for the whole access.
- R9: `done` is high for exactly one cycle, the cycle right after the last recovery cycle. `busy` is low in that same cycle.
- R10: After synchronous reset, `rd_n`=1, `wr_n`=1, `busy`=0 and `done`=0.
- R11: Whenever `busy` is low, both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access; accepted only while not busy |
| is_write | input | 1 | 1 = write strobe, 0 = read strobe |
| is_cmd | input | 1 | 1 = task-file command fields, 0 = data fields |
| timing_word | input | 32 | Packed timing word |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse at the end of an access |

## Verification
Some properties are checked by assertions on every cycle:
- the done pulse lasts one cycle, falls while busy is low and follows a recovery cycle;
- the strobes stay high when idle and are never both low;
- the phase counter never exceeds its captured field;
- the captured configuration and direction hold steady while busy.

Other behaviour can only be shown by the bench's scenarios, which measure the phase lengths from the outside:
- the exact cycle counts of each phase for both field groups;
- that the flag bits do not change the waveform;
- that late input changes and a start raised mid-access leave the running access untouched and add no extra access.

// File: rtl/ata_strb_pkg.sv
package ata_strb_pkg;

    localparam int WORD_W  = 32;
    localparam int SETUP_W = 3;
    localparam int ACT_W   = 5;
    localparam int REC_W   = 4;
    localparam int CNT_W   = (ACT_W > REC_W) ? ((ACT_W > SETUP_W) ? ACT_W : SETUP_W)
                                             : ((REC_W > SETUP_W) ? REC_W : SETUP_W);

    // field positions (LSB) inside the packed timing word
    localparam int D_REC_LSB = 0;
    localparam int D_ACT_LSB = 4;
    localparam int C_REC_LSB = 9;
    localparam int C_ACT_LSB = 13;
    localparam int D_SET_LSB = 22;
    localparam int C_SET_LSB = 25;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [ACT_W-1:0]   active;
        logic [REC_W-1:0]   recov;
    } strb_cfg_t;

    function automatic strb_cfg_t unpack_data(input logic [WORD_W-1:0] w);
        strb_cfg_t c;
        c.setup  = w[D_SET_LSB +: SETUP_W];
        c.active = w[D_ACT_LSB +: ACT_W];
        c.recov  = w[D_REC_LSB +: REC_W];
        return c;
    endfunction

    function automatic strb_cfg_t unpack_cmd(input logic [WORD_W-1:0] w);
        strb_cfg_t c;
        c.setup  = w[C_SET_LSB +: SETUP_W];
        c.active = w[C_ACT_LSB +: ACT_W];
        c.recov  = w[C_REC_LSB +: REC_W];
        return c;
    endfunction

endpackage

// File: rtl/strb_field_sel.sv
module strb_field_sel
    import ata_strb_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              is_cmd,
    output strb_cfg_t         cfg
);
    strb_cfg_t data_cfg;
    strb_cfg_t cmd_cfg;

    // mode flags and the ultra-DMA cycle field do not shape the strobe
    logic unused_bits;
    assign unused_bits = &{1'b0, word[31:28], word[21:18]};

    always_comb begin
        data_cfg = unpack_data(word);
        cmd_cfg  = unpack_cmd(word);
        cfg      = is_cmd ? cmd_cfg : data_cfg;
    end
endmodule

// File: rtl/strb_phase_seq.sv
module strb_phase_seq
    import ata_strb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      is_write,
    input  strb_cfg_t cfg_in,
    output logic      rd_n,
    output logic      wr_n,
    output logic      busy,
    output logic      done
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    strb_cfg_t        cfg_q;
    logic             wr_q;
    logic             done_q;
    logic             last_cyc;

    assign last_cyc = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        wr_q    <= is_write;
                        phase_q <= PH_SETUP;
                        cnt_q   <= CNT_W'(cfg_in.setup);
                    end
                end
                PH_SETUP: begin
                    if (last_cyc) begin
                        phase_q <= PH_ACTIVE;
                        cnt_q   <= CNT_W'(cfg_q.active);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (last_cyc) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= CNT_W'(cfg_q.recov);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (last_cyc) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    logic strobe_on;
    assign strobe_on = (phase_q == PH_ACTIVE);
    assign rd_n      = ~(strobe_on & ~wr_q);
    assign wr_n      = ~(strobe_on &  wr_q);
    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;

    // R9: done is one cycle, while idle, right after recovery
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_done_after_recov: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(phase_q) == PH_RECOV);
    // R11: strobes high while idle
    a_r11_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_n && wr_n));
    // R8: never both strobes low; direction held during an access
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    a_r8_dir_steady: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(wr_q)));
    // R6/R7: captured configuration held while busy
    a_r6_cfg_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(cfg_q)));
    // R2: counter bounded by the captured field of each phase
    a_r2_cnt_active: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACTIVE) |-> (cnt_q <= CNT_W'(cfg_q.active)));
    a_r1_cnt_setup: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SETUP) |-> (cnt_q <= CNT_W'(cfg_q.setup)));
    a_r3_cnt_recov: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RECOV) |-> (cnt_q <= CNT_W'(cfg_q.recov)));
endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
    import ata_strb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_write,
    input  logic              is_cmd,
    input  logic [WORD_W-1:0] timing_word,
    output logic              rd_n,
    output logic              wr_n,
    output logic              busy,
    output logic              done
);
    strb_cfg_t sel_cfg;

    strb_field_sel u_sel (
        .word   (timing_word),
        .is_cmd (is_cmd),
        .cfg    (sel_cfg)
    );

    strb_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_write (is_write),
        .cfg_in   (sel_cfg),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .busy     (busy),
        .done     (done)
    );

    // R7: a start while busy must not end the access early
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !rd_n) |=> busy);
endmodule

// File: tb/test_ata_strobe_timer.sv
module test_ata_strobe_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        is_write;
    logic        is_cmd;
    logic [31:0] timing_word;
    logic        rd_n, wr_n, busy, done;

    always #4 clk = ~clk;

    ata_strobe_timer i_ata_strobe_timer (
        .clk(clk), .rst(rst), .start(start), .is_write(is_write),
        .is_cmd(is_cmd), .timing_word(timing_word),
        .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done)
    );

    typedef struct {
        int    s;
        int    a;
        int    r;
        bit    wr;
        bit    cmd;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input logic [31:0] w, input bit wr, input bit cmd,
                                      input string tag);
        exp_t e;
        if (cmd) begin
            e.s = int'((w >> 25) & 32'h7) + 1;
            e.a = int'((w >> 13) & 32'h1f) + 1;
            e.r = int'((w >> 9) & 32'hf) + 1;
        end else begin
            e.s = int'((w >> 22) & 32'h7) + 1;
            e.a = int'((w >> 4) & 32'h1f) + 1;
            e.r = int'(w & 32'hf) + 1;
        end
        e.wr = wr; e.cmd = cmd; e.tag = tag;
        return e;
    endfunction

    // monitor: measure each access and compare with the scoreboard
    bit in_acc = 0;
    int cs, ca, cr;
    bit wrong_strobe;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (busy) begin
                if (!in_acc) begin
                    in_acc = 1; cs = 0; ca = 0; cr = 0; wrong_strobe = 0;
                end
                if (done) chk(0, "R9 done while busy", 1, 0);
                if (!rd_n || !wr_n) begin
                    ca++;
                    if (exp_q.size() > 0)
                        if ((exp_q[0].wr && !rd_n) || (!exp_q[0].wr && !wr_n))
                            wrong_strobe = 1;
                end else if (ca == 0) cs++;
                else cr++;
            end else if (in_acc) begin
                in_acc = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected access", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cs == e.s, e.cmd ? "R4 setup" : "R1 setup", cs, e.s);
                    chk(ca == e.a, e.cmd ? "R4 active" : "R2 active", ca, e.a);
                    chk(cr == e.r, e.cmd ? "R4 recovery" : "R3 recovery", cr, e.r);
                    chk(done == 1'b1, "R9 done at end", int'(done), 1);
                    chk(!wrong_strobe, "R8 other strobe high", int'(wrong_strobe), 0);
                    chk(cs + ca + cr == e.s + e.a + e.r, e.tag,
                        cs + ca + cr, e.s + e.a + e.r);
                end
            end else begin
                if (done) chk(0, "R9 done extra cycle", 1, 0);
                chk(rd_n && wr_n, "R11 idle strobes", int'({rd_n, wr_n}), 3);
            end
        end
    end

    task automatic access(input logic [31:0] w, input bit wr, input bit cmd,
                          input string tag, input bit disturb, input bit change);
        @(negedge clk);
        timing_word = w; is_write = wr; is_cmd = cmd; start = 1'b1;
        exp_q.push_back(make_exp(w, wr, cmd, tag));
        @(negedge clk);
        start = 1'b0;
        if (change) begin
            timing_word = ~w; is_write = ~wr; is_cmd = ~cmd;
        end
        if (disturb) begin
            @(negedge clk);
            @(negedge clk);
            start = 1'b1; timing_word = 32'h0; is_write = ~wr;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        chk(0, "watchdog", 0, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; is_write = 1'b0; is_cmd = 1'b0; timing_word = '0;
        repeat (3) @(negedge clk);
        chk(rd_n == 1'b1, "R10 rd_n", int'(rd_n), 1);
        chk(wr_n == 1'b1, "R10 wr_n", int'(wr_n), 1);
        chk(busy == 1'b0, "R10 busy", int'(busy), 0);
        chk(done == 1'b0, "R10 done", int'(done), 0);
        rst = 1'b0;
        // R1 R2 R3 minimum fields
        access(32'h0000_0000, 1'b0, 1'b0, "R1 min data read", 0, 0);
        access((32'd5 << 22) | (32'd9 << 4) | 32'd12, 1'b1, 1'b0, "R2 data write", 0, 0);
        // R4 command fields at maximum, data fields differ
        access((32'd7 << 25) | (32'd31 << 13) | (32'd15 << 9) | 32'h0000_0012, 1'b0, 1'b1,
               "R4 cmd read max", 0, 0);
        access(32'h0c8a_9c62, 1'b1, 1'b1, "R4 cmd write", 0, 0);
        // R3 maximum data fields
        access((32'd7 << 22) | (32'd31 << 4) | 32'd15, 1'b0, 1'b0, "R3 data max", 0, 0);
        // R5 flag and unused bits set
        access(32'hF03C_0000 | (32'd2 << 22) | (32'd3 << 4) | 32'd1, 1'b1, 1'b0,
               "R5 flags ignored", 0, 0);
        // R6 inputs change after capture
        access((32'd1 << 22) | (32'd6 << 4) | 32'd4, 1'b1, 1'b0, "R6 late change", 0, 1);
        // R7 start during busy
        access((32'd3 << 25) | (32'd8 << 13) | (32'd5 << 9), 1'b0, 1'b1,
               "R7 start while busy", 1, 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);
        chk(busy == 1'b0, "R7 no extra access", int'(busy), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule